// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block rebuilds the four integer condition flags (negative, zero, overflow, carry) of a 32-bit datapath some time after the operation that produced them. The datapath keeps only the result word, the second operand and a small code for the kind of operation. When a later instruction needs the flags, this block turns that saved pair into the flags. Each operation kind has its own carry and overflow rule, so the adder never has to produce flags on the fast path.

Beside the evaluator sits an extended add/subtract path, used for multi-word arithmetic. It takes two operands, the current extend bit and the previous zero flag. It returns the sum or difference with the extend bit folded in, the new extend bit and a five-bit flag set. The zero flag in that set can only be cleared, never newly set, so a zero test across a multi-word chain stays correct. Both paths are purely combinational.

Top module: `ccr_flag_rebuilder`

## Requirements
- R1: The class code on `op_class` is 0 pass-through, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-with-extend, 7 subtract-with-extend, 8 shift. `flags_nzvc` is packed {N,Z,V,C} with C in bit 0. For every class except pass-through, Z is 1 exactly when the evaluated result is zero, and N is the sign bit of that result.
- R2: Pass-through returns `saved_res[3:0]` unchanged on `flags_nzvc`.
- R3: Logic class clears V and C.
- R4: Add class: C is 1 when `saved_res` is unsigned below `saved_src`. V is 1 when the two words differ in sign and the recovered first operand (`saved_res - saved_src`) has the sign of `saved_src`.
- R5: Add-with-extend: C is 1 when `saved_res` is unsigned below or equal to `saved_src`. V uses the first operand recovered as `saved_res - saved_src - 1`.
- R6: Subtract: the minuend is rebuilt as `saved_res + saved_src`. C is 1 when that minuend is unsigned below `saved_src`. V is the sign bit of (minuend XOR result) AND (minuend XOR source).
- R7: Byte and word compare apply the R6 rule to bits [7:0] and [15:0] only. N, Z, V and C all refer to that width, and the upper bits have no effect.
- R8: Subtract-with-extend: the minuend is `saved_res + saved_src + 1`. C is 1 when it is unsigned below or equal to `saved_src`.
- R9: Shift class takes N and Z from `saved_res`, clears V, and sets C when `saved_src` is non-zero.
- R10: Codes 9 to 15 drive `flags_nzvc` to zero and raise `class_err`. Defined codes keep `class_err` low.
- R11: Extended path: `xop_res` is `xop_a + xop_b + x_cur` when `xop_sub` is 0, or `xop_a - xop_b - x_cur` when it is 1. The new X is the carry or borrow of that full operation, and it equals C. `xop_flags` is packed {X,N,Z,V,C}.
- R12: Extended path zero is sticky: `xop_flags[2]` is 1 only when `xop_res` is zero and `prior_z` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 4 | Operation class code of the saved pair |
| saved_res | input | 32 | Saved result word |
| saved_src | input | 32 | Saved source operand (carry-out bit for shifts) |
| flags_nzvc | output | 4 | Rebuilt {N,Z,V,C} |
| class_err | output | 1 | Undefined class code |
| xop_sub | input | 1 | Extended path: 1 subtract, 0 add |
| xop_a | input | 32 | Extended path first operand |
| xop_b | input | 32 | Extended path second operand |
| x_cur | input | 1 | Current extend bit |
| prior_z | input | 1 | Zero flag before the extended operation |
| xop_res | output | 32 | Extended path result |
| xop_flags | output | 5 | Extended path {X,N,Z,V,C} |

## Verification
The main evaluator and the extended path work at the same moment, and the extended path holds its own copy of the evaluator core. A fault in the shared rules could therefore show up on one output set and not the other. The bench drives both at once with different classes, for example a byte compare on the main inputs while a subtract-with-borrow runs on the extended inputs. It judges each output set against its own independently computed value. A second case runs an add-with-extend on the main inputs and a plain add on the extended path, so the same rule module is exercised with and without the extra one in one sample.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_PASS  = 4'd0,
    CLS_LOGIC = 4'd1,
    CLS_ADD   = 4'd2,
    CLS_SUB   = 4'd3,
    CLS_CMPB  = 4'd4,
    CLS_CMPW  = 4'd5,
    CLS_ADDX  = 4'd6,
    CLS_SUBX  = 4'd7,
    CLS_SHIFT = 4'd8
  } ccr_cls_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/ccr_sub_rule.sv
// Subtract-style flag recovery at a chosen width: the minuend is rebuilt
// from the stored difference and subtrahend.
module ccr_sub_rule #(
  parameter int W = 32
) (
  input  logic [W-1:0]  dest,
  input  logic [W-1:0]  src,
  input  logic          ext,
  output ccr_pkg::nzvc_t flags
);
  logic [W-1:0] minu;

  always_comb begin
    minu    = dest + src + {{(W-1){1'b0}}, ext};
    flags.n = dest[W-1];
    flags.z = (dest == '0);
    flags.c = ext ? (minu <= src) : (minu < src);
    flags.v = (minu[W-1] ^ dest[W-1]) & (minu[W-1] ^ src[W-1]);
  end

  // A zero difference with no extend bit can never have borrowed.
  always_comb begin
    if (!ext && dest == '0)
      assert_zero_diff_no_borrow_R6: assert (!flags.c);
  end

endmodule

// File: rtl/ccr_rebuild.sv
module ccr_rebuild
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [DW-1:0]    dest,
  input  logic [DW-1:0]    src,
  output nzvc_t            flags,
  output logic             err
);
  localparam int NW     = 3;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  function automatic nzvc_t nz_only(input logic [DW-1:0] d);
    nzvc_t f;
    f.n = d[DW-1];
    f.z = (d == '0);
    f.v = 1'b0;
    f.c = 1'b0;
    return f;
  endfunction

  function automatic nzvc_t add_rule(input logic [DW-1:0] d,
                                     input logic [DW-1:0] s,
                                     input logic          e);
    nzvc_t f;
    logic [DW-1:0] opa;
    opa = d - s - {{(DW-1){1'b0}}, e};
    f   = nz_only(d);
    f.c = e ? (d <= s) : (d < s);
    f.v = (s[DW-1] ^ d[DW-1]) & ~(opa[DW-1] ^ s[DW-1]);
    return f;
  endfunction

  logic  is_subx;
  nzvc_t sub_f [NW];

  assign is_subx = (cls == CLS_SUBX);

  // Index 0: full width (subtract, subtract-with-extend);
  // 1: byte compare; 2: word compare.
  for (genvar gi = 0; gi < NW; gi++) begin : g_sub
    localparam int W = (gi == 0) ? DW : ((gi == 1) ? BYTE_W : WORD_W);
    logic ext_sel;
    if (gi == 0) begin : g_ext
      assign ext_sel = is_subx;
    end else begin : g_noext
      assign ext_sel = 1'b0;
    end
    ccr_sub_rule #(.W(W)) u_rule (
      .dest  (dest[W-1:0]),
      .src   (src[W-1:0]),
      .ext   (ext_sel),
      .flags (sub_f[gi])
    );
  end

  always_comb begin
    err   = 1'b0;
    flags = '0;
    case (ccr_cls_e'(cls))
      CLS_PASS:  flags = dest[3:0];
      CLS_LOGIC: flags = nz_only(dest);
      CLS_ADD:   flags = add_rule(dest, src, 1'b0);
      CLS_ADDX:  flags = add_rule(dest, src, 1'b1);
      CLS_SUB:   flags = sub_f[0];
      CLS_SUBX:  flags = sub_f[0];
      CLS_CMPB:  flags = sub_f[1];
      CLS_CMPW:  flags = sub_f[2];
      CLS_SHIFT: begin
        flags   = nz_only(dest);
        flags.c = (src != '0);
      end
      default:   err = 1'b1;
    endcase
  end

  always_comb begin
    if (err)
      assert_bad_class_clear_R10: assert (flags == '0);
    if (!err && cls != CLS_PASS)
      assert_n_z_exclusive_R1: assert (!(flags.n && flags.z));
    if (cls == CLS_LOGIC)
      assert_logic_no_vc_R3: assert (!flags.v && !flags.c);
    if (cls == CLS_SHIFT && src == '0)
      assert_shift_no_carry_R9: assert (!flags.c && !flags.v);
  end

endmodule

// File: rtl/ccr_extarith.sv
// Extended add/subtract: folds the extend bit into the operation and
// names the class under which the result must be re-evaluated.
module ccr_extarith
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             sub_mode,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             x_in,
  output logic [DW-1:0]    res,
  output logic             x_out,
  output logic [CLS_W-1:0] cls
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    if (sub_mode) begin
      res   = x_in ? (a - b - ONE) : (a - b);
      x_out = x_in ? (a <= b) : (a < b);
      cls   = x_in ? CLS_SUBX : CLS_SUB;
    end else begin
      res   = x_in ? (a + b + ONE) : (a + b);
      x_out = x_in ? (res <= b) : (res < b);
      cls   = x_in ? CLS_ADDX : CLS_ADD;
    end
  end

  always_comb begin
    if (!x_in && b == '0)
      assert_no_carry_on_zero_R11: assert (!x_out);
  end

endmodule

// File: rtl/ccr_flag_rebuilder.sv
module ccr_flag_rebuilder
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_class,
  input  logic [DW-1:0] saved_res,
  input  logic [DW-1:0] saved_src,
  output logic [3:0]    flags_nzvc,
  output logic          class_err,
  input  logic          xop_sub,
  input  logic [DW-1:0] xop_a,
  input  logic [DW-1:0] xop_b,
  input  logic          x_cur,
  input  logic          prior_z,
  output logic [DW-1:0] xop_res,
  output logic [4:0]    xop_flags
);
  nzvc_t            main_f;
  nzvc_t            xr_f;
  logic             xr_err;
  logic             x_new;
  logic [CLS_W-1:0] x_cls;
  logic             z_sticky;

  ccr_rebuild #(.DW(DW)) u_main (
    .cls   (op_class),
    .dest  (saved_res),
    .src   (saved_src),
    .flags (main_f),
    .err   (class_err)
  );

  ccr_extarith #(.DW(DW)) u_xarith (
    .sub_mode (xop_sub),
    .a        (xop_a),
    .b        (xop_b),
    .x_in     (x_cur),
    .res      (xop_res),
    .x_out    (x_new),
    .cls      (x_cls)
  );

  ccr_rebuild #(.DW(DW)) u_xrebuild (
    .cls   (x_cls),
    .dest  (xop_res),
    .src   (xop_b),
    .flags (xr_f),
    .err   (xr_err)
  );

  assign flags_nzvc = main_f;
  assign z_sticky   = xr_f.z & prior_z;
  assign xop_flags  = {x_new, xr_f.n, z_sticky, xr_f.v, xr_f.c};

  always_comb begin
    assert_ext_class_valid_R11: assert (!xr_err);
    assert_x_matches_carry_R11: assert (xop_flags[4] == xop_flags[0]);
    if (xop_flags[2])
      assert_z_never_set_R12: assert (prior_z && xop_res == '0);
  end

endmodule

// File: tb/ccr_flag_rebuilder_tb.sv
module ccr_flag_rebuilder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_class = '0;
  logic [31:0] saved_res = '0;
  logic [31:0] saved_src = '0;
  logic [3:0]  flags_nzvc;
  logic        class_err;
  logic        xop_sub = 1'b0;
  logic [31:0] xop_a = '0;
  logic [31:0] xop_b = '0;
  logic        x_cur = 1'b0;
  logic        prior_z = 1'b0;
  logic [31:0] xop_res;
  logic [4:0]  xop_flags;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ccr_flag_rebuilder u_dut (
    .op_class, .saved_res, .saved_src, .flags_nzvc, .class_err,
    .xop_sub, .xop_a, .xop_b, .x_cur, .prior_z, .xop_res, .xop_flags
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model: returns {err, N, Z, V, C}.
  function automatic logic [4:0] model(input logic [3:0] c, input logic [31:0] d,
                                       input logic [31:0] s);
    logic [32:0] t;
    logic [31:0] a, m;
    logic [8:0]  tb;
    logic [7:0]  mb;
    logic [16:0] tw;
    logic [15:0] mw;
    logic n, z, v, cy;
    n = d[31]; z = (d == 0); v = 0; cy = 0;
    case (c)
      4'd0: return {1'b0, d[3:0]};
      4'd1: ;
      4'd2: begin a = d - s; t = {1'b0, a} + {1'b0, s}; cy = t[32];
                  v = (a[31] == s[31]) && (d[31] != s[31]); end
      4'd6: begin a = d - s - 1; t = {1'b0, a} + {1'b0, s} + 33'd1; cy = t[32];
                  v = (a[31] == s[31]) && (d[31] != s[31]); end
      4'd3: begin m = d + s; t = {1'b0, m} - {1'b0, s}; cy = t[32];
                  v = (m[31] != s[31]) && (d[31] != m[31]); end
      4'd7: begin m = d + s + 1; t = {1'b0, m} - {1'b0, s} - 33'd1; cy = t[32];
                  v = (m[31] != s[31]) && (d[31] != m[31]); end
      4'd4: begin mb = d[7:0] + s[7:0]; tb = {1'b0, mb} - {1'b0, s[7:0]}; cy = tb[8];
                  v = (mb[7] != s[7]) && (d[7] != mb[7]); n = d[7]; z = (d[7:0] == 0); end
      4'd5: begin mw = d[15:0] + s[15:0]; tw = {1'b0, mw} - {1'b0, s[15:0]}; cy = tw[16];
                  v = (mw[15] != s[15]) && (d[15] != mw[15]); n = d[15]; z = (d[15:0] == 0); end
      4'd8: cy = (s != 0);
      default: return 5'b10000;
    endcase
    return {1'b0, n, z, v, cy};
  endfunction

  task automatic run_main(input string req, input logic [3:0] c,
                          input logic [31:0] d, input logic [31:0] s);
    logic [4:0] e;
    @(negedge clk);
    op_class = c; saved_res = d; saved_src = s;
    #1;
    e = model(c, d, s);
    chk(req, {27'd0, class_err, flags_nzvc}, {27'd0, e});
  endtask

  task automatic run_ext(input string req, input logic sb, input logic [31:0] a,
                         input logic [31:0] b, input logic x, input logic pz);
    logic [33:0] full;
    logic [31:0] r;
    logic        xe, ve;
    @(negedge clk);
    xop_sub = sb; xop_a = a; xop_b = b; x_cur = x; prior_z = pz;
    #1;
    if (sb) full = {2'b0, a} - {2'b0, b} - {33'd0, x};
    else    full = {2'b0, a} + {2'b0, b} + {33'd0, x};
    r  = full[31:0];
    xe = full[32];
    ve = sb ? ((a[31] != b[31]) && (r[31] != a[31]))
            : ((a[31] == b[31]) && (r[31] != a[31]));
    chk({req, " res"}, xop_res, r);
    chk({req, " flags"}, {27'd0, xop_flags},
        {27'd0, xe, r[31], (r == 0) && pz, ve, xe});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset flags", {28'd0, flags_nzvc}, 32'd0);
    chk("R10 reset err", {31'd0, class_err}, 32'd0);
  endtask

  task automatic t_pass();
    run_main("R2 pass", 4'd0, 32'hABCD_123A, 32'h5);
    chk("R2 pass literal", {28'd0, flags_nzvc}, 32'hA);
    run_main("R2 pass", 4'd0, 32'hFFFF_FFF5, 32'h0);
  endtask

  task automatic t_logic();
    run_main("R1 R3 logic zero", 4'd1, 32'h0, 32'hFFFF_FFFF);
    chk("R1 logic zero literal", {28'd0, flags_nzvc}, 32'b0100);
    run_main("R1 R3 logic neg", 4'd1, 32'h8000_0000, 32'h1);
    run_main("R3 logic pos", 4'd1, 32'h7, 32'h0);
  endtask

  task automatic t_add();
    run_main("R4 add carry zero", 4'd2, 32'h0, 32'h1);
    chk("R4 add literal", {28'd0, flags_nzvc}, 32'b0101);
    run_main("R4 add overflow", 4'd2, 32'h8000_0000, 32'h7FFF_FFFF);
    run_main("R4 add plain", 4'd2, 32'h10, 32'h3);
  endtask

  task automatic t_addx();
    run_main("R5 addx equal", 4'd6, 32'h5, 32'h5);
    chk("R5 addx equal literal", {28'd0, flags_nzvc}, 32'b0001);
    run_main("R5 addx above", 4'd6, 32'h6, 32'h5);
    run_main("R5 addx ovf", 4'd6, 32'h8000_0000, 32'h7FFF_FFFF);
  endtask

  task automatic t_sub();
    run_main("R6 sub ovf", 4'd3, 32'h7FFF_FFFF, 32'h1);
    chk("R6 sub ovf literal", {28'd0, flags_nzvc}, 32'b0010);
    run_main("R6 sub borrow", 4'd3, 32'hFFFF_FFFF, 32'h1);
    run_main("R6 sub zero", 4'd3, 32'h0, 32'h1234);
  endtask

  task automatic t_cmp();
    run_main("R7 cmpb zero", 4'd4, 32'h1234_5600, 32'hFFFF_FFFF);
    chk("R7 cmpb upper ignored", {28'd0, flags_nzvc}, 32'b0100);
    run_main("R7 cmpb neg", 4'd4, 32'h0000_0080, 32'h0000_0001);
    run_main("R7 cmpb borrow", 4'd4, 32'hAA00_00FF, 32'h0000_0001);
    run_main("R7 cmpw ovf", 4'd5, 32'h0000_7FFF, 32'h0000_0001);
    chk("R7 cmpw ovf literal", {28'd0, flags_nzvc}, 32'b0010);
    run_main("R7 cmpw zero", 4'd5, 32'h5555_0000, 32'h0001_0000);
  endtask

  task automatic t_subx();
    run_main("R8 subx equal", 4'd7, 32'hFFFF_FFFF, 32'h0);
    chk("R8 subx literal", {28'd0, flags_nzvc}, 32'b1001);
    run_main("R8 subx plain", 4'd7, 32'h3, 32'h4);
    run_main("R8 subx ovf", 4'd7, 32'h7FFF_FFFF, 32'h0);
  endtask

  task automatic t_shift();
    run_main("R9 shift carry", 4'd8, 32'h8000_0000, 32'h1);
    chk("R9 shift literal", {28'd0, flags_nzvc}, 32'b1001);
    run_main("R9 shift nocarry", 4'd8, 32'h0, 32'h0);
  endtask

  task automatic t_bad();
    for (int c = 9; c < 16; c++)
      run_main("R10 bad class", c[3:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_main("R10 defined after bad", 4'd1, 32'h1, 32'h0);
  endtask

  task automatic t_ext();
    run_ext("R11 add nox", 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
    run_ext("R11 add x", 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b1, 1'b1);
    run_ext("R11 sub x", 1'b1, 32'h5, 32'h5, 1'b1, 1'b1);
    chk("R11 sub x literal", {27'd0, xop_flags}, 32'b11001);
    run_ext("R11 sub nox", 1'b1, 32'h8000_0000, 32'h1, 1'b0, 1'b0);
    run_ext("R11 add wrap x", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_sticky();
    run_ext("R12 zero no prior", 1'b1, 32'h5, 32'h5, 1'b0, 1'b0);
    chk("R12 z stays clear", {31'd0, xop_flags[2]}, 32'd0);
    run_ext("R12 zero with prior", 1'b1, 32'h5, 32'h5, 1'b0, 1'b1);
    chk("R12 z kept", {31'd0, xop_flags[2]}, 32'd1);
    run_ext("R12 nonzero clears", 1'b0, 32'h1, 32'h1, 1'b0, 1'b1);
    run_ext("R12 add x to zero", 1'b0, 32'hFFFF_FFFE, 32'h1, 1'b1, 1'b1);
  endtask

  task automatic t_concurrent();
    logic [4:0] e;
    @(negedge clk);
    op_class = 4'd4; saved_res = 32'h0000_0180; saved_src = 32'h0000_0001;
    xop_sub = 1'b1; xop_a = 32'h0; xop_b = 32'h0; x_cur = 1'b1; prior_z = 1'b1;
    #1;
    e = model(4'd4, 32'h0000_0180, 32'h1);
    chk("R7 concurrent main", {27'd0, class_err, flags_nzvc}, {27'd0, e});
    chk("R11 concurrent ext res", xop_res, 32'hFFFF_FFFF);
    chk("R11 R12 concurrent ext flags", {27'd0, xop_flags}, 32'b11001);
    run_main("R5 concurrent addx", 4'd6, 32'h2, 32'h7);
    run_ext("R11 concurrent add", 1'b0, 32'h2, 32'h7, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_logic();
    t_add();
    t_addx();
    t_sub();
    t_cmp();
    t_subx();
    t_shift();
    t_bad();
    t_ext();
    t_sticky();
    t_concurrent();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule